// File: doc/BRIEF.md
# Prioritised GPIO Interrupt Controller

This block collects up to 128 general-purpose input lines and turns them into four processor interrupt requests, one for each of four priority levels. Every line has its own configuration word. The word picks how the line triggers (off, high level, low level, rising edge, falling edge or either edge), gives the line a two-bit priority, and sets an idle-wake bit. Lines are grouped into 32-bit banks. Each bank has a pending register, a pair of enable registers (one sets bits, one clears them) and a device-select register. A read-only encoder register names the line that software should service next.

The block also routes the synchronised level of two chosen lines to a pair of DMA trigger outputs. It raises a wake output whenever a line marked for idle-wake has a request pending. Software reaches everything over a plain register bus with a write strobe, a read strobe, a byte address and 32-bit data. Reads return data one cycle after the strobe. The address map uses byte addresses:

- Pending for bank b is at 0x000+4b. Enable-set is at 0x010+4b, enable-clear is at 0x020+4b and device-select is at 0x030+4b. Bits 7:4 pick the register group and bits 3:2 pick the bank.
- The encoder register is at 0x040 and the DMA select register is at 0x044.
- The configuration word of line n is at 0x1000+4n. The top address bit selects this array.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `wake_o`, `dma_trig_o` and `dev_sel_o` are all zero. All enables and configuration words read 0. The encoder register reads 0x0000007F.
- R2: In an enable-set write (0x010+4b), each 1 bit enables that line of bank b. In an enable-clear write (0x020+4b), each 1 bit disables it. Zero bits leave the enable unchanged. Either address reads back the bank's enables.
- R3: A configuration word has the trigger type in bits 2:0, encoded 0 off, 1 high level, 2 low level, 3 rising, 4 falling, 5 both edges. A line whose type is 0, 6 or 7 never becomes pending.
- R4: An edge-mode line latches pending on the selected edge of its synchronised input. It stays pending until a 1 is written to its bit of the pending register (0x000+4b). Writing all ones clears every latched request in the bank.
- R5: A level-mode line is pending while its synchronised input is at the active level. An acknowledge clears it for one cycle only, and it then comes back.
- R6: `irq_o[p]` is high exactly when some line that is both enabled and pending has priority p. Priority lives in config bits 5:4, and 0 is the most urgent. A pending line that is not enabled raises no request.
- R7: The encoder register returns the valid flag in bit 31 and the line index in bits 6:0. The line chosen is the pending, enabled line with the smallest priority value, with ties going to the lower index. When no line qualifies, the register reads 0x0000007F.
- R8: The DMA select register holds field k in bits 8k+7:8k. Bits 6:0 of the field name a line. `dma_trig_o[k]` follows that line's synchronised level, and field bit 7 is ignored.
- R9: Writing a 1 to a bit of device-select (0x030+4b) sets that line's `dev_sel_o` bit. Zero bits change nothing. The register reads back.
- R10: `wake_o` is high while any pending line has its idle-wake bit (config bit 6) set, whether or not that line is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| pin_i | input | NUM_LINES | Asynchronous input lines |
| irq_o | output | 4 | Interrupt request per priority level |
| wake_o | output | 1 | Idle-wake request |
| dma_trig_o | output | 2 | DMA trigger outputs |
| dev_sel_o | output | NUM_LINES | Lines handed to their device function |

## Verification
Each input change passes through two synchroniser flops before it reaches the pending flop. The outputs are registered after that. As a result, `irq_o`, `wake_o` and the encoder value move on the fourth rising edge after a pin change, and `dma_trig_o` moves on the third. The bench changes pins at a falling edge and waits four falling edges before it samples any of these outputs.

Register writes take effect on the edge where the strobe is sampled, and outputs derived from them follow one edge later. The bench therefore waits two falling edges after an acknowledge or enable write before it checks an interrupt output or reads the encoder register. Reads are captured one edge after the strobe, so the bench samples read data at the following falling edge.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  typedef enum logic [2:0] {
    TRIG_OFF    = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_LVL_LO = 3'd2,
    TRIG_RISE   = 3'd3,
    TRIG_FALL   = 3'd4,
    TRIG_BOTH   = 3'd5
  } trig_e;

  typedef struct packed {
    logic       wake;
    logic [1:0] prio;
    logic [2:0] mode;
  } line_cfg_t;

  localparam logic [3:0] GRP_PEND   = 4'h0;
  localparam logic [3:0] GRP_ENSET  = 4'h1;
  localparam logic [3:0] GRP_ENCLR  = 4'h2;
  localparam logic [3:0] GRP_DEVSEL = 4'h3;
  localparam logic [3:0] GRP_MISC   = 4'h4;

  localparam int BANK_BITS = 32;
  localparam int MAX_LINES = 128;
endpackage

// File: rtl/gpic_line.sv
module gpic_line
  import gpic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [2:0] mode_i,
  input  logic       ack_i,
  output logic       lvl_o,
  output logic       pend_o
);
  logic s1_q, s2_q, prev_q, pend_q, pend_d;
  logic rise, fall;

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  always_comb begin
    case (trig_e'(mode_i))
      TRIG_LVL_HI: pend_d = s2_q & ~ack_i;
      TRIG_LVL_LO: pend_d = ~s2_q & ~ack_i;
      TRIG_RISE:   pend_d = rise | (pend_q & ~ack_i);
      TRIG_FALL:   pend_d = fall | (pend_q & ~ack_i);
      TRIG_BOTH:   pend_d = rise | fall | (pend_q & ~ack_i);
      default:     pend_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign lvl_o  = s2_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/gpic_prio_enc.sv
module gpic_prio_enc #(
  parameter int N      = 128,
  parameter int PRIO_W = 2,
  localparam int LEVELS = 1 << PRIO_W,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]        active_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                valid_o
);
  logic [LEVELS-1:0] hit;
  logic [IDX_W-1:0]  cand [LEVELS];

  always_comb begin
    for (int p = 0; p < LEVELS; p++) begin
      hit[p]  = 1'b0;
      cand[p] = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (active_i[i] && prio_i[i*PRIO_W +: PRIO_W] == PRIO_W'(p)) begin
          hit[p]  = 1'b1;
          cand[p] = IDX_W'(i);
        end
      end
    end
    idx_o   = IDX_W'(N - 1);
    valid_o = 1'b0;
    for (int p = LEVELS - 1; p >= 0; p--) begin
      if (hit[p]) begin
        idx_o   = cand[p];
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpic_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int ADDR_W    = 13,
  parameter int DMA_CH    = 2,
  parameter int PRIO_W    = 2,
  localparam int LEVELS  = 1 << PRIO_W,
  localparam int BANKS   = NUM_LINES / BANK_BITS,
  localparam int LINE_W  = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [LEVELS-1:0]    irq_o,
  output logic                 wake_o,
  output logic [DMA_CH-1:0]    dma_trig_o,
  output logic [NUM_LINES-1:0] dev_sel_o
);
  logic              cfg_hit;
  logic [3:0]        grp;
  logic [1:0]        wsel;
  logic [LINE_W-1:0] cfg_idx;
  logic              cfg_ok;

  assign cfg_hit = bus_addr_i[ADDR_W-1];
  assign grp     = bus_addr_i[7:4];
  assign wsel    = bus_addr_i[3:2];
  assign cfg_idx = bus_addr_i[2 +: LINE_W];
  assign cfg_ok  = cfg_hit && (32'(cfg_idx) < NUM_LINES);

  line_cfg_t              cfg_q [NUM_LINES];
  logic [NUM_LINES-1:0]   en_q, devsel_q, pend, lvl, wake_vec, lane_w;
  logic [NUM_LINES-1:0]   ack_v, set_v, clr_v, dev_v, active;
  logic [NUM_LINES*3-1:0] mode_flat;
  logic [NUM_LINES*PRIO_W-1:0] prio_flat;
  logic [8*DMA_CH-1:0]    dma_sel_q;
  logic [LINE_W-1:0]      enc_idx, enc_idx_q;
  logic                   enc_valid, enc_valid_q;
  logic [LEVELS-1:0]      irq_q;
  logic                   wake_q;
  logic [DMA_CH-1:0]      dma_q;
  logic [31:0]            rd_d, rd_q;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      lane_w[i]                   = (wsel == 2'(i / BANK_BITS)) && bus_wdata_i[i % BANK_BITS];
      mode_flat[i*3 +: 3]         = cfg_q[i].mode;
      prio_flat[i*PRIO_W +: PRIO_W] = cfg_q[i].prio;
      wake_vec[i]                 = cfg_q[i].wake;
    end
  end

  always_comb begin
    ack_v = '0;
    set_v = '0;
    clr_v = '0;
    dev_v = '0;
    if (bus_wr_i && !cfg_hit) begin
      case (grp)
        GRP_PEND:   ack_v = lane_w;
        GRP_ENSET:  set_v = lane_w;
        GRP_ENCLR:  clr_v = lane_w;
        GRP_DEVSEL: dev_v = lane_w;
        default: ;
      endcase
    end
  end

  assign active = pend & en_q;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      gpic_line u_line (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i[g]),
        .mode_i (mode_flat[g*3 +: 3]),
        .ack_i  (ack_v[g]),
        .lvl_o  (lvl[g]),
        .pend_o (pend[g])
      );
    end
  endgenerate

  gpic_prio_enc #(.N(NUM_LINES), .PRIO_W(PRIO_W)) u_enc (
    .active_i (active),
    .prio_i   (prio_flat),
    .idx_o    (enc_idx),
    .valid_o  (enc_valid)
  );

  // configuration array and bank registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) cfg_q[i] <= '0;
      en_q      <= '0;
      devsel_q  <= '0;
      dma_sel_q <= '0;
    end else begin
      if (bus_wr_i && cfg_ok)
        cfg_q[cfg_idx] <= '{wake: bus_wdata_i[6], prio: bus_wdata_i[5:4], mode: bus_wdata_i[2:0]};
      if (bus_wr_i && !cfg_hit && grp == GRP_MISC && wsel == 2'd1)
        dma_sel_q <= bus_wdata_i[8*DMA_CH-1:0];
      en_q     <= (en_q | set_v) & ~clr_v;
      devsel_q <= devsel_q | dev_v;
    end
  end

  // registered outputs
  logic [MAX_LINES-1:0] lvl_pad, pend_pad, en_pad, dev_pad;
  assign lvl_pad  = MAX_LINES'(lvl);
  assign pend_pad = MAX_LINES'(pend);
  assign en_pad   = MAX_LINES'(en_q);
  assign dev_pad  = MAX_LINES'(devsel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q       <= '0;
      wake_q      <= 1'b0;
      enc_idx_q   <= LINE_W'(NUM_LINES - 1);
      enc_valid_q <= 1'b0;
      dma_q       <= '0;
    end else begin
      for (int p = 0; p < LEVELS; p++) begin
        irq_q[p] <= 1'b0;
        for (int i = 0; i < NUM_LINES; i++)
          if (active[i] && cfg_q[i].prio == PRIO_W'(p)) irq_q[p] <= 1'b1;
      end
      wake_q      <= |(pend & wake_vec);
      enc_idx_q   <= enc_idx;
      enc_valid_q <= enc_valid;
      for (int k = 0; k < DMA_CH; k++)
        dma_q[k] <= lvl_pad[dma_sel_q[8*k +: 7]];
    end
  end

  // read path
  always_comb begin
    rd_d = '0;
    if (cfg_hit) begin
      if (cfg_ok)
        rd_d = {25'd0, cfg_q[cfg_idx].wake, cfg_q[cfg_idx].prio, 1'b0, cfg_q[cfg_idx].mode};
    end else begin
      case (grp)
        GRP_PEND:   rd_d = pend_pad[{wsel, 5'd0} +: 32];
        GRP_ENSET,
        GRP_ENCLR:  rd_d = en_pad[{wsel, 5'd0} +: 32];
        GRP_DEVSEL: rd_d = dev_pad[{wsel, 5'd0} +: 32];
        GRP_MISC: begin
          if (wsel == 2'd0) begin
            rd_d     = 32'(enc_idx_q);
            rd_d[31] = enc_valid_q;
          end else if (wsel == 2'd1) begin
            rd_d = 32'(dma_sel_q);
          end
        end
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (bus_rd_i) rd_q <= rd_d;
  end

  assign bus_rdata_o = rd_q;
  assign irq_o       = irq_q;
  assign wake_o      = wake_q;
  assign dma_trig_o  = dma_q;
  assign dev_sel_o   = devsel_q;
endmodule

// File: rtl/gpic_checker.sv
module gpic_checker #(
  parameter int NUM_LINES = 128,
  parameter int ADDR_W    = 13
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_wr_i,
  input logic [ADDR_W-1:0]      bus_addr_i,
  input logic [31:0]            bus_wdata_i,
  input logic [3:0]             irq_o,
  input logic [NUM_LINES-1:0]   en_q,
  input logic [NUM_LINES-1:0]   pend,
  input logic [NUM_LINES*3-1:0] mode_flat,
  input logic                   enc_valid_q
);
  localparam logic [ADDR_W-1:0] A_ENSET0 = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_ENCLR0 = ADDR_W'(12'h020);

  AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == A_ENSET0) |=> ((en_q[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2
  AST_ENCLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == A_ENCLR0) |=> ((en_q[31:0] & $past(bus_wdata_i)) == 32'd0)); // R2
  AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (mode_flat[2:0] == 3'd0) |=> !pend[0]); // R3
  AST_IRQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (|irq_o) |-> $past(|(pend & en_q))); // R6
  AST_ENC_AGREES_IRQ: assert property (@(posedge clk) disable iff (rst)
    enc_valid_q == (|irq_o)); // R7
endmodule

bind gpio_irq_ctrl gpic_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .en_q        (en_q),
  .pend        (pend),
  .mode_flat   (mode_flat),
  .enc_valid_q (enc_valid_q)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr = 1'b0, rd = 1'b0;
  logic [12:0]  addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic [NL-1:0] pins = '0;
  logic [3:0]   irq;
  logic         wake;
  logic [1:0]   dma;
  logic [NL-1:0] devsel;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins), .irq_o(irq),
    .wake_o(wake), .dma_trig_o(dma), .dev_sel_o(devsel)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [12:0] cfga(input int line);
    return 13'h1000 + 13'(line * 4);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);
    chk("R1 dma", dma, 0);
    chk("R1 devsel", devsel, 0);
    rreg(13'h040, d); chk("R1 encoder idle", d, 32'h7F);
    rreg(13'h010, d); chk("R1 enables", d, 0);
    rreg(cfga(0), d); chk("R1 config", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wreg(13'h014, 32'hF0);
    rreg(13'h014, d); chk("R2 set", d, 32'hF0);
    wreg(13'h014, 32'h0);
    rreg(13'h024, d); chk("R2 zero set no effect", d, 32'hF0);
    wreg(13'h024, 32'h30);
    rreg(13'h014, d); chk("R2 clear", d, 32'hC0);
    wreg(13'h024, 32'h0);
    rreg(13'h014, d); chk("R2 zero clear no effect", d, 32'hC0);
    wreg(13'h024, 32'hFFFF_FFFF);
    rreg(13'h014, d); chk("R2 clear all", d, 0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wreg(cfga(5), 32'h23);   // rising, prio 2
    wreg(cfga(6), 32'h04);   // falling, prio 0
    wreg(cfga(7), 32'h35);   // both, prio 3
    wreg(13'h010, 32'hE0);
    rreg(cfga(5), d); chk("R3 config readback", d, 32'h23);
    @(negedge clk); pins[5] = 1'b1; cyc(4);
    chk("R6 rising prio2", irq, 4'b0100);
    rreg(13'h000, d); chk("R4 pending bit", d, 32'h20);
    @(negedge clk); pins[5] = 1'b0; cyc(4);
    chk("R4 latched after input drops", irq, 4'b0100);
    wreg(13'h000, 32'h20); cyc(2);
    chk("R4 ack clears", irq, 0);
    @(negedge clk); pins[6] = 1'b1; cyc(4);
    chk("R4 falling ignores rise", irq, 0);
    @(negedge clk); pins[6] = 1'b0; cyc(4);
    chk("R6 falling prio0", irq, 4'b0001);
    wreg(13'h000, 32'h40); cyc(2);
    @(negedge clk); pins[7] = 1'b1; cyc(4);
    chk("R4 both rise", irq, 4'b1000);
    wreg(13'h000, 32'h80); cyc(2);
    chk("R4 both ack", irq, 0);
    @(negedge clk); pins[7] = 1'b0; cyc(4);
    chk("R4 both fall", irq, 4'b1000);
    wreg(13'h000, 32'h80); cyc(2);
    wreg(13'h020, 32'hE0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wreg(cfga(40), 32'h11);  // level high, prio 1
    wreg(13'h014, 32'h100);
    @(negedge clk); pins[40] = 1'b1; cyc(4);
    chk("R5 level high", irq, 4'b0010);
    wreg(13'h004, 32'h100); cyc(3);
    rreg(13'h004, d); chk("R5 reasserts after ack", d, 32'h100);
    @(negedge clk); pins[40] = 1'b0; cyc(4);
    chk("R5 level drops", irq, 0);
    wreg(cfga(41), 32'h12);  // level low, prio 1
    wreg(13'h014, 32'h200); cyc(3);
    chk("R5 level low", irq, 4'b0010);
    @(negedge clk); pins[41] = 1'b1; cyc(4);
    chk("R5 level low released", irq, 0);
    wreg(cfga(40), 0); wreg(cfga(41), 0);
    wreg(13'h024, 32'h300);
    @(negedge clk); pins[41] = 1'b0;
  endtask

  task automatic t_off;
    logic [31:0] d;
    wreg(cfga(9), 32'h06);   // unused code 6
    wreg(13'h010, 32'h300);
    @(negedge clk); pins[8] = 1'b1; pins[9] = 1'b1; cyc(4);
    chk("R3 off/unused no irq", irq, 0);
    rreg(13'h000, d); chk("R3 off/unused no pending", d & 32'h300, 0);
    @(negedge clk); pins[8] = 1'b0; pins[9] = 1'b0; cyc(4);
    rreg(13'h000, d); chk("R3 off after fall", d & 32'h300, 0);
    wreg(13'h020, 32'h300); wreg(cfga(9), 0);
    wreg(cfga(10), 32'h03);  // rising, not enabled
    @(negedge clk); pins[10] = 1'b1; cyc(4);
    chk("R6 not enabled no irq", irq, 0);
    rreg(13'h000, d); chk("R6 pending without enable", d & 32'h400, 32'h400);
    wreg(13'h000, 32'h400); wreg(cfga(10), 0);
    @(negedge clk); pins[10] = 1'b0;
  endtask

  task automatic t_encoder;
    logic [31:0] d;
    wreg(cfga(12), 32'h23);
    wreg(cfga(20), 32'h23);
    wreg(cfga(100), 32'h13);
    wreg(13'h010, 32'h0010_1000);
    wreg(13'h01C, 32'h10);
    @(negedge clk); pins[12] = 1'b1; pins[20] = 1'b1; pins[100] = 1'b1; cyc(4);
    chk("R6 two levels", irq, 4'b0110);
    rreg(13'h040, d); chk("R7 lowest prio value wins", d, 32'h8000_0064);
    wreg(13'h00C, 32'h10); cyc(2);
    rreg(13'h040, d); chk("R7 tie lowest index", d, 32'h8000_000C);
    wreg(13'h000, 32'h1000); cyc(2);
    rreg(13'h040, d); chk("R7 next", d, 32'h8000_0014);
    for (int b = 0; b < 4; b++) wreg(13'(b * 4), 32'hFFFF_FFFF);
    cyc(2);
    rreg(13'h040, d); chk("R7/R4 all cleared idle", d, 32'h7F);
    chk("R4 all ones ack", irq, 0);
    @(negedge clk); pins[12] = 1'b0; pins[20] = 1'b0; pins[100] = 1'b0;
    wreg(cfga(12), 0); wreg(cfga(20), 0); wreg(cfga(100), 0);
    wreg(13'h020, 32'hFFFF_FFFF); wreg(13'h02C, 32'hFFFF_FFFF);
  endtask

  task automatic t_dma;
    logic [31:0] d;
    wreg(13'h044, 32'h0000_C603);  // ch0 line 3, ch1 line 70 with bit7 set
    rreg(13'h044, d); chk("R8 readback", d, 32'hC603);
    @(negedge clk); pins[3] = 1'b1; cyc(4);
    chk("R8 ch0", dma, 2'b01);
    @(negedge clk); pins[70] = 1'b1; cyc(4);
    chk("R8 ch1 bit7 ignored", dma, 2'b11);
    @(negedge clk); pins[3] = 1'b0; cyc(4);
    chk("R8 ch0 follows level", dma, 2'b10);
    @(negedge clk); pins[70] = 1'b0; cyc(4);
  endtask

  task automatic t_devsel;
    logic [31:0] d;
    wreg(13'h038, 32'h5);
    chk("R9 set bank2", devsel[95:64], 32'h5);
    wreg(13'h038, 32'h2);
    chk("R9 zeros keep bits", devsel[95:64], 32'h7);
    rreg(13'h038, d); chk("R9 readback", d, 32'h7);
    chk("R9 other banks", devsel[63:0], 0);
  endtask

  task automatic t_wake;
    wreg(cfga(50), 32'h43);  // rising with idle-wake, not enabled
    @(negedge clk); pins[50] = 1'b1; cyc(4);
    chk("R10 wake", wake, 1'b1);
    wreg(13'h004, 32'h0004_0000); cyc(2);
    chk("R10 wake clears", wake, 1'b0);
    @(negedge clk); pins[50] = 1'b0;
    wreg(cfga(50), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    t_reset;
    t_enable;
    t_edges;
    t_level;
    t_off;
    t_encoder;
    t_dma;
    t_devsel;
    t_wake;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule